// File: doc/BRIEF.md
# Dual-Channel Two-Wire Wiper Register Controller

This block is the serial control front end of a dual digital potentiometer. It acts as a slave on a two-wire (I2C) bus. It oversamples SCL and SDA with a fast system clock and keeps two 8-bit tap codes, one for each resistor channel. It also keeps a shared power-down flag. When that flag is set, the switch fabric is told to open the high end of each resistor and tie the wiper to the low end.

A write transaction starts with the address byte. Next comes a command byte: its top bit picks the channel and the bit below it sets or clears power-down. Every data byte after that, up to STOP, replaces the tap code of the picked channel. A read transaction has no pointer byte. It returns the code of the channel that the last command byte picked, and keeps returning it for as long as the master acknowledges. The slave address is 0101_1 followed by two strap bits. A build option can tie both strap bits high.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: The slave responds only to the 7-bit address {0,1,0,1,1,strap[1],strap[0]}, which is sent MSB first and followed by the R/W bit (1 = read). With FIXED_ADDR=1 the two low address bits are 1 whatever the straps are.
- R2: On the ninth SCL pulse after a matched address byte, and after each command byte and write data byte, the slave pulls SDA low.
- R3: In the command byte, bit 7 picks the channel (0 = channel 1, 1 = channel 2) and bit 6 is the power-down value. Bits 5..0 have no effect on any output.
- R4: While power-down is set, both shdn_o bits are 1 and both tap outputs keep their stored codes. Data bytes written during power-down still update the stored code. Clearing power-down leaves the stored codes on the taps.
- R5: Every data byte after the command byte, until STOP, overwrites the picked channel's tap code. The other channel does not change.
- R6: A read shifts out the picked channel's code MSB first, starting right after the address acknowledge. The same code is repeated while the master ACKs. A master NACK ends the read with SDA released.
- R7: After reset both tap codes are 0x80, power-down is clear, channel 1 is picked and SDA is released.
- R8: A START or STOP in the middle of a byte discards that byte, changes no tap code and returns the slave to address matching.
- R9: A write that holds only the address and command bytes still updates the channel pick and the power-down flag.
- R10: After an address mismatch the slave leaves SDA released and ignores the bus until the next START.
- R11: The slave changes its SDA pull-down only while SCL is low, so it never creates a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_strap_i | input | 2 | Low two address bits (ignored when FIXED_ADDR=1) |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain control) |
| tap1_o | output | 8 | Stored tap code of channel 1 |
| tap2_o | output | 8 | Stored tap code of channel 2 |
| shdn_o | output | 2 | Power-down indication, one bit per channel |

## Verification
Two instances share one modelled open-drain bus. One uses strap inputs and the other uses the fixed address, so a frame meant for one must leave the other untouched. This separates correct address decoding from acceptance of any address. Directed frames cover command-only writes, burst writes, writes made while powered down, repeated reads, a START inside a data byte and a wrong address. Each of these exposes a different fault: a stale channel pick, a lost burst byte, a write that power-down blocks, or a partial byte that gets committed. Seeded random frames then vary the channel, the power-down bit, the don't-care command bits and the burst length. After each frame the bench reads back and compares against its own model.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INSTR,
    ST_INSTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RD_ACK
  } link_state_e;

  // 7-bit bus address: fixed prefix plus two strap bits
  function automatic logic [6:0] slave_addr(input logic fixed_var, input logic [1:0] strap);
    logic [1:0] low;
    low = fixed_var ? 2'b11 : strap;
    return {5'b01011, low};
  endfunction

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  // [STAGES-1] is the synchronized level, [STAGES] the previous sample
  logic [STAGES:0] scl_p, sda_p;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[STAGES-1:0], scl_i};
      sda_p <= {sda_p[STAGES-1:0], sda_i};
    end
  end

  assign scl_lvl   = scl_p[STAGES-1];
  assign sda_lvl   = sda_p[STAGES-1];
  assign scl_prev  = scl_p[STAGES];
  assign sda_prev  = sda_p[STAGES];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/link_fsm.sv
module link_fsm
  import dpot_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         start_evt,
  input  logic         stop_evt,
  input  logic         sda_lvl,
  input  logic [6:0]   my_addr,
  input  logic [W-1:0] rd_value,
  output logic         sda_pull,
  output logic         instr_evt,
  output logic         wr_evt,
  output logic [W-1:0] rx_byte,
  output logic         in_idle
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  link_state_e state;
  logic [W-1:0]     sr;
  logic [CNT_W-1:0] cnt;
  logic             mack;
  logic             rx_state, byte_done;

  assign rx_state  = (state == ST_ADDR) || (state == ST_INSTR) || (state == ST_WDATA);
  assign byte_done = rx_state && scl_fall && (cnt == FULL);
  assign instr_evt = byte_done && (state == ST_INSTR);
  assign wr_evt    = byte_done && (state == ST_WDATA);
  assign rx_byte   = sr;
  assign in_idle   = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sr       <= '0;
      cnt      <= '0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_INSTR, ST_WDATA: begin
          if (scl_rise && cnt != FULL) begin
            sr  <= {sr[W-2:0], sda_lvl};
            cnt <= cnt + 1'b1;
          end else if (byte_done) begin
            if (state == ST_ADDR) begin
              if (sr[W-1:1] == my_addr) begin
                sda_pull <= 1'b1;
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_pull <= 1'b1;
              state    <= (state == ST_INSTR) ? ST_INSTR_ACK : ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (sr[0]) begin
              state    <= ST_RDATA;
              sr       <= rd_value;
              sda_pull <= ~rd_value[W-1];
            end else begin
              state    <= ST_INSTR;
              sda_pull <= 1'b0;
            end
          end
        end
        ST_INSTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            cnt      <= '0;
            state    <= ST_WDATA;
            sda_pull <= 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt == LAST) begin
              sda_pull <= 1'b0;
              cnt      <= '0;
              state    <= ST_RD_ACK;
            end else begin
              sr       <= {sr[W-2:0], 1'b0};
              sda_pull <= ~sr[W-2];
              cnt      <= cnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              state    <= ST_RDATA;
              sr       <= rd_value;
              sda_pull <= ~rd_value[W-1];
              cnt      <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int TAP_W = 8,
  parameter int NCH   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      instr_evt,
  input  logic                      wr_evt,
  input  logic [TAP_W-1:0]          rx_byte,
  output logic [NCH-1:0][TAP_W-1:0] taps,
  output logic [$clog2(NCH)-1:0]    sel,
  output logic                      shdn,
  output logic [TAP_W-1:0]          rd_value
);
  localparam int SEL_W = $clog2(NCH);
  localparam logic [TAP_W-1:0] MID = {1'b1, {(TAP_W-1){1'b0}}};

  // Command byte: channel pick in the top bits, power-down just below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      shdn <= 1'b0;
    end else if (instr_evt) begin
      sel  <= rx_byte[TAP_W-1 -: SEL_W];
      shdn <= rx_byte[TAP_W-1-SEL_W];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        taps[g] <= MID;
      else if (wr_evt && sel == SEL_W'(g))
        taps[g] <= rx_byte;
    end
  end

  assign rd_value = taps[sel];
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
  import dpot_pkg::*;
#(
  parameter bit FIXED_ADDR  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_strap_i,
  output logic       sda_pull_o,
  output logic [7:0] tap1_o,
  output logic [7:0] tap2_o,
  output logic [1:0] shdn_o
);
  localparam int SEL_W = $clog2(NUM_CH);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic instr_evt, wr_evt, in_idle, shdn;
  logic [BYTE_W-1:0] rx_byte, rd_value;
  logic [SEL_W-1:0]  wr_sel;
  logic [NUM_CH-1:0][BYTE_W-1:0] taps;
  logic [6:0] my_addr;

  assign my_addr = slave_addr(FIXED_ADDR, addr_strap_i);

  bus_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  link_fsm #(.W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl),
    .my_addr(my_addr), .rd_value(rd_value), .sda_pull(sda_pull_o),
    .instr_evt(instr_evt), .wr_evt(wr_evt), .rx_byte(rx_byte), .in_idle(in_idle)
  );

  wiper_bank #(.TAP_W(BYTE_W), .NCH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .instr_evt(instr_evt), .wr_evt(wr_evt),
    .rx_byte(rx_byte), .taps(taps), .sel(wr_sel), .shdn(shdn), .rd_value(rd_value)
  );

  assign tap1_o = taps[0];
  assign tap2_o = taps[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sd
    assign shdn_o[c] = shdn;
  end
endmodule

// File: rtl/dual_wiper_ctrl_chk.sv
module dual_wiper_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       in_idle,
  input logic       sda_pull_o,
  input logic       wr_evt,
  input logic       instr_evt,
  input logic       wr_sel,
  input logic [7:0] rx_byte,
  input logic [7:0] tap1_o,
  input logic [7:0] tap2_o,
  input logic [1:0] shdn_o
);
  // R5
  wr_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !wr_sel) |=> (tap1_o == $past(rx_byte)) && $stable(tap2_o));
  // R5
  wr_ch2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wr_sel) |=> (tap2_o == $past(rx_byte)) && $stable(tap1_o));
  // R8
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable(tap1_o) && $stable(tap2_o));
  // R4
  shdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_evt |=> $stable(shdn_o));
  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_pull_o);
  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !scl_lvl);
endmodule

bind dual_wiper_ctrl dual_wiper_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .in_idle(in_idle),
  .sda_pull_o(sda_pull_o), .wr_evt(wr_evt), .instr_evt(instr_evt),
  .wr_sel(wr_sel[0]), .rx_byte(rx_byte), .tap1_o(tap1_o), .tap2_o(tap2_o),
  .shdn_o(shdn_o)
);

// File: tb/dual_wiper_ctrl_bench.sv
module dual_wiper_ctrl_bench;
  localparam int Q = 5;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pull_a, pull_b;
  logic [7:0] t1a, t2a, t1b, t2b;
  logic [1:0] sda_a, sda_b;
  wire sda_line = sda_m & ~pull_a & ~pull_b;

  int n_chk = 0, n_fail = 0, glitches = 0;
  bit done = 0;
  logic [7:0] exp_tap [2];
  logic       exp_sel, exp_sd;

  always #4 clk = ~clk;

  dual_wiper_ctrl #(.FIXED_ADDR(1'b0)) u_dual_wiper_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .addr_strap_i(STRAP),
    .sda_pull_o(pull_a), .tap1_o(t1a), .tap2_o(t2a), .shdn_o(sda_a));

  dual_wiper_ctrl #(.FIXED_ADDR(1'b1)) u_dual_wiper_ctrl_fixed (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .addr_strap_i(2'b00),
    .sda_pull_o(pull_b), .tap1_o(t1b), .tap2_o(t2b), .shdn_o(sda_b));

  // R11 monitor: pull-down may only move while SCL is low
  logic prev_pa = 1'b0, prev_pb = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && ((pull_a != prev_pa) || (pull_b != prev_pb))) glitches++;
    prev_pa <= pull_a;
    prev_pb <= pull_b;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] low, input logic rw);
    return {5'b01011, low, rw};
  endfunction

  function automatic logic [7:0] cmd_byte(input logic ch, input logic sd, input logic [5:0] junk);
    return {ch, sd, junk};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    tick(1); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    tick(1); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(4 * Q);
  endtask

  task automatic send_bit(input logic b);
    tick(1); sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    tick(1); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    read_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) read_bit(v[i]);
    send_bit(~master_ack);
  endtask

  // Full write on the strapped instance, model update included
  task automatic do_write(input logic ch, input logic sd, input logic [5:0] junk,
                          input int nbytes, input logic [7:0] d0, input string req);
    logic ak;
    logic [7:0] d;
    bus_start;
    send_byte(addr_byte(STRAP, 1'b0), ak); chk({req, " R2 addr ack"}, ak, 1);
    send_byte(cmd_byte(ch, sd, junk), ak); chk({req, " R2 cmd ack"}, ak, 1);
    exp_sel = ch; exp_sd = sd;
    for (int k = 0; k < nbytes; k++) begin
      d = d0 + 8'(k * 37);
      send_byte(d, ak); chk({req, " R2 data ack"}, ak, 1);
      exp_tap[ch] = d;
    end
    bus_stop;
  endtask

  task automatic check_outputs(input string req);
    chk({req, " tap1"}, t1a, exp_tap[0]);
    chk({req, " tap2"}, t2a, exp_tap[1]);
    chk({req, " shdn"}, sda_a, {exp_sd, exp_sd});
  endtask

  task automatic do_read(input int nbytes, input string req);
    logic ak;
    logic [7:0] v;
    bus_start;
    send_byte(addr_byte(STRAP, 1'b1), ak); chk({req, " R2 read addr ack"}, ak, 1);
    for (int k = 0; k < nbytes; k++) begin
      recv_byte(k != nbytes - 1, v);
      chk({req, " R6 read data"}, v, exp_tap[exp_sel]);
    end
    tick(Q);
    chk({req, " R6 released after NACK"}, pull_a, 0);
    bus_stop;
  endtask

  initial begin
    logic ak;
    void'($urandom(32'h1BADC0DE));
    exp_tap[0] = 8'h80; exp_tap[1] = 8'h80; exp_sel = 1'b0; exp_sd = 1'b0;
    tick(10);
    // R7 reset state
    chk("R7 pull", pull_a, 0);
    check_outputs("R7 reset");
    rst_n = 1'b1;
    tick(10);
    check_outputs("R7 after release");
    do_read(1, "R7 read ch1 midscale");

    // R5 single byte to channel 1, don't-care bits set
    do_write(1'b0, 1'b0, 6'h3F, 1, 8'h3C, "R3 R5 ch1");
    check_outputs("R3 R5 ch1");

    // R4 power-down on channel 2, codes kept
    do_write(1'b1, 1'b1, 6'h00, 0, 8'h00, "R4 R9 sd on");
    check_outputs("R4 R9 sd on");
    do_write(1'b1, 1'b1, 6'h15, 1, 8'hA5, "R4 write in sd");
    check_outputs("R4 write in sd");
    do_read(1, "R4 read in sd");
    do_write(1'b1, 1'b0, 6'h2A, 0, 8'h00, "R4 sd off");
    check_outputs("R4 sd off");

    // R5 burst
    do_write(1'b0, 1'b0, 6'h01, 4, 8'h11, "R5 burst");
    check_outputs("R5 burst");
    // R6 repeated read
    do_read(3, "R6 repeat");

    // R9 command-only write flips the read channel
    do_write(1'b1, 1'b0, 6'h00, 0, 8'h00, "R9 pick ch2");
    do_read(2, "R9 read ch2");

    // R10 wrong address: nobody answers, nothing changes
    bus_start;
    send_byte(addr_byte(2'b01, 1'b0), ak); chk("R10 no ack", ak, 0);
    send_byte(cmd_byte(1'b0, 1'b1, 6'h0), ak); chk("R10 ignored cmd", ak, 0);
    send_byte(8'h00, ak); chk("R10 ignored data", ak, 0);
    bus_stop;
    check_outputs("R10 unchanged");
    chk("R1 fixed inst untouched", {t1b, t2b}, 16'h8080);

    // R1 fixed-address instance answers 0101111, strapped one does not
    bus_start;
    send_byte(addr_byte(2'b11, 1'b0), ak); chk("R1 fixed ack", ak, 1);
    send_byte(cmd_byte(1'b0, 1'b0, 6'h0), ak);
    send_byte(8'h5A, ak);
    bus_stop;
    chk("R1 fixed tap1", t1b, 8'h5A);
    check_outputs("R1 strapped unchanged");

    // R8 START inside a data byte aborts it
    bus_start;
    send_byte(addr_byte(STRAP, 1'b0), ak);
    send_byte(cmd_byte(1'b1, 1'b0, 6'h0), ak);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start;
    send_byte(addr_byte(STRAP, 1'b1), ak); chk("R8 readdress ack", ak, 1);
    begin
      logic [7:0] v;
      recv_byte(1'b0, v);
      chk("R8 partial byte dropped", v, exp_tap[1]);
    end
    bus_stop;
    check_outputs("R8 after abort");
    // R8 STOP inside a data byte
    bus_start;
    send_byte(addr_byte(STRAP, 1'b0), ak);
    send_byte(cmd_byte(1'b1, 1'b0, 6'h0), ak);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_stop;
    check_outputs("R8 stop abort");

    // Seeded random frames
    for (int it = 0; it < 24; it++) begin
      logic ch, sd;
      logic [5:0] junk;
      int nb;
      logic [7:0] d0;
      ch = 1'($urandom % 2); sd = 1'($urandom % 2);
      junk = 6'($urandom); nb = int'($urandom % 4); d0 = 8'($urandom);
      do_write(ch, sd, junk, nb, d0, "R5 random");
      check_outputs("R3 R4 random");
      do_read(2, "R6 random");
    end

    chk("R11 pull moved while SCL high", glitches, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule